// File: doc/BRIEF.md
# Event Timestamp Bank Recorder

This block keeps a short history of system events together with the time at which each one happened. The clock logic supplies the live calendar time on its input fields. These fields are sub-second (in 1/128 s steps), seconds, minutes, hours, date, month and year. When an enabled event arrives, the block copies that time into a record and adds a flags byte that says which source caused the record.

There are four record banks, and bank 0 always holds the newest record. On each capture the older records move one bank toward bank 3. An overwrite setting controls what happens after four records are held:

- With overwrite on, the record in bank 3 is pushed out.
- With overwrite off, the history stops changing until it is cleared.

The event sources are:

- a digital input, whose active edge is chosen by a polarity bit;
- a pulse for a switch from backup supply to main supply;
- a pulse for a switch from main supply to backup supply;
- a low-battery pulse.

A clear strobe empties all banks. Each stored record raises a one-cycle interrupt pulse.

Top module: `evt_stamp_bank`

## Requirements
- R1: After reset all four banks read 0 and `stamp_irq` is low.
- R2: An accepted event stores a record in bank 0, in the same clock edge that samples the event. The record holds the live time fields at that edge. The layout is bits [7:0] sub-second, [15:8] seconds, [23:16] minutes, [31:24] hours, [39:32] date, [47:40] month, [55:48] year and [63:56] flags. Bank g appears at `bank_flat[g*64 +: 64]`, and the previous bank g-1 moves into bank g.
- R3: The flags byte holds the cause code in bits [2:0], with bits [7:3] zero. The codes are 1 for a digital-input edge, 2 for a backup-to-main switch, 3 for a main-to-backup switch and 4 for low battery. A bank that holds no record reads code 0.
- R4: Each source has its own enable: `en_lowbat` for low battery, `en_supply` for both supply-switch directions, and `en_din` for the digital input. An event from a disabled source is ignored, and every event is ignored while `func_en` is low. An ignored event leaves the banks unchanged and raises no interrupt.
- R5: With `din_pol` = 0, a falling edge of `din_lvl` is the digital-input event; with `din_pol` = 1, a rising edge is. The opposite edge is ignored.
- R6: When several enabled sources fire in the same cycle, only one record is stored. Its code is chosen by priority: low battery first, then backup-to-main, then main-to-backup, then the digital input.
- R7: With `ovw_en` low, once four records are held, further events leave all banks unchanged and raise no interrupt.
- R8: With `ovw_en` high, an event stored while four records are held shifts the banks and discards the record that was in bank 3.
- R9: A `clr_stb` cycle sets all banks to 0 and empties the history, even if an event is present in the same cycle. Recording then starts again from bank 0.
- R10: `stamp_irq` is high for exactly the cycle after each stored record and low after every ignored event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | 1 | Master enable for recording |
| ovw_en | input | 1 | Overwrite oldest record once full |
| clr_stb | input | 1 | One-cycle strobe that empties all banks |
| en_lowbat | input | 1 | Enable for the low-battery source |
| en_supply | input | 1 | Enable for both supply-switch sources |
| en_din | input | 1 | Enable for the digital-input source |
| din_pol | input | 1 | Digital-input edge select: 0 falling, 1 rising |
| din_lvl | input | 1 | Digital-input level, synchronous to clk |
| to_main_p | input | 1 | Pulse: backup-to-main supply switch |
| to_bak_p | input | 1 | Pulse: main-to-backup supply switch |
| lowbat_p | input | 1 | Pulse: low-battery detection |
| t_subsec | input | 8 | Live sub-second count (1/128 s) |
| t_sec | input | 8 | Live seconds |
| t_min | input | 8 | Live minutes |
| t_hour | input | 8 | Live hours |
| t_date | input | 8 | Live date |
| t_month | input | 8 | Live month |
| t_year | input | 8 | Live year |
| bank_flat | output | 256 | Four 64-bit records, bank 0 lowest |
| stamp_irq | output | 1 | One-cycle pulse per stored record |

## Verification
The assertions assume three things about the inputs:

- `din_lvl` is already synchronous to `clk`;
- the supply and low-battery inputs are pulses one cycle wide;
- a full history can be recognised by a nonzero code in bank 3.

The last assumption holds only because every stored record carries a code from 1 to 4. The bench drives every input at the falling clock edge and keeps each pulse to one cycle. It changes the polarity only while the digital input stays put, so no edge appears from a setting change.

// File: rtl/evt_stamp_pkg.sv
package evt_stamp_pkg;

    localparam int FIELD_W = 8;
    localparam int NUM_FIELDS = 8;
    localparam int REC_W = FIELD_W * NUM_FIELDS;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_DIN     = 3'd1,
        CAUSE_TO_MAIN = 3'd2,
        CAUSE_TO_BAK  = 3'd3,
        CAUSE_LOWBAT  = 3'd4
    } cause_e;

    typedef struct packed {
        logic [FIELD_W-1:0] year;
        logic [FIELD_W-1:0] month;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] hour;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] subsec;
    } time_snap_t;

    typedef struct packed {
        logic [FIELD_W-1:0] flags;
        time_snap_t         when;
    } stamp_rec_t;

    function automatic logic [FIELD_W-1:0] flags_of(input cause_e c);
        logic [FIELD_W-1:0] f;
        f = '0;
        f[CODE_W-1:0] = c;
        return f;
    endfunction

    function automatic stamp_rec_t make_rec(input time_snap_t t, input cause_e c);
        stamp_rec_t r;
        r.flags = flags_of(c);
        r.when  = t;
        return r;
    endfunction

endpackage

// File: rtl/din_edge_det.sv
module din_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic pol,
    input  logic lvl,
    output logic edge_hit
);
    logic prev_q;
    logic primed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= 1'b0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= lvl;
            primed_q <= 1'b1;
        end
    end

    // No edge is reported until one level has been sampled after reset.
    always_comb begin
        if (!primed_q)
            edge_hit = 1'b0;
        else if (pol)
            edge_hit = lvl & ~prev_q;
        else
            edge_hit = ~lvl & prev_q;
    end
endmodule

// File: rtl/trig_select.sv
module trig_select
    import evt_stamp_pkg::*;
(
    input  logic   func_en,
    input  logic   en_lowbat,
    input  logic   en_supply,
    input  logic   en_din,
    input  logic   lowbat_p,
    input  logic   to_main_p,
    input  logic   to_bak_p,
    input  logic   din_edge,
    output logic   hit,
    output cause_e cause
);
    logic lb_ok, tm_ok, tb_ok, di_ok;

    assign lb_ok = func_en & en_lowbat & lowbat_p;
    assign tm_ok = func_en & en_supply & to_main_p;
    assign tb_ok = func_en & en_supply & to_bak_p;
    assign di_ok = func_en & en_din & din_edge;

    always_comb begin
        if (lb_ok)      cause = CAUSE_LOWBAT;
        else if (tm_ok) cause = CAUSE_TO_MAIN;
        else if (tb_ok) cause = CAUSE_TO_BAK;
        else if (di_ok) cause = CAUSE_DIN;
        else            cause = CAUSE_NONE;
    end

    assign hit = lb_ok | tm_ok | tb_ok | di_ok;
endmodule

// File: rtl/stamp_bank_store.sv
module stamp_bank_store
    import evt_stamp_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ovw,
    input  logic       hit,
    input  cause_e     cause,
    input  time_snap_t now,
    output stamp_rec_t banks [NUM_BANKS],
    output logic       irq
);
    localparam int CNT_W = $clog2(NUM_BANKS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BANKS);

    logic [CNT_W-1:0] held_q;
    logic             room;
    logic             take;

    assign room = (held_q != FULL);
    assign take = hit & ~clr & (ovw | room);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            held_q <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= take;
            if (take && room)
                held_q <= held_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            banks[0] <= '0;
        else if (take)
            banks[0] <= make_rec(now, cause);
    end

    for (genvar g = 1; g < NUM_BANKS; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (rst || clr)
                banks[g] <= '0;
            else if (take)
                banks[g] <= banks[g-1];
        end
    end
endmodule

// File: rtl/evt_stamp_bank.sv
module evt_stamp_bank
    import evt_stamp_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         func_en,
    input  logic                         ovw_en,
    input  logic                         clr_stb,
    input  logic                         en_lowbat,
    input  logic                         en_supply,
    input  logic                         en_din,
    input  logic                         din_pol,
    input  logic                         din_lvl,
    input  logic                         to_main_p,
    input  logic                         to_bak_p,
    input  logic                         lowbat_p,
    input  logic [7:0]                   t_subsec,
    input  logic [7:0]                   t_sec,
    input  logic [7:0]                   t_min,
    input  logic [7:0]                   t_hour,
    input  logic [7:0]                   t_date,
    input  logic [7:0]                   t_month,
    input  logic [7:0]                   t_year,
    output logic [NUM_BANKS*REC_W-1:0]   bank_flat,
    output logic                         stamp_irq
);
    logic       din_edge;
    logic       hit;
    cause_e     cause;
    time_snap_t now;
    stamp_rec_t banks [NUM_BANKS];

    assign now = '{year: t_year, month: t_month, date: t_date, hour: t_hour,
                   min: t_min, sec: t_sec, subsec: t_subsec};

    din_edge_det u_edge (
        .clk      (clk),
        .rst      (rst),
        .pol      (din_pol),
        .lvl      (din_lvl),
        .edge_hit (din_edge)
    );

    trig_select u_sel (
        .func_en   (func_en),
        .en_lowbat (en_lowbat),
        .en_supply (en_supply),
        .en_din    (en_din),
        .lowbat_p  (lowbat_p),
        .to_main_p (to_main_p),
        .to_bak_p  (to_bak_p),
        .din_edge  (din_edge),
        .hit       (hit),
        .cause     (cause)
    );

    stamp_bank_store #(.NUM_BANKS(NUM_BANKS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_stb),
        .ovw   (ovw_en),
        .hit   (hit),
        .cause (cause),
        .now   (now),
        .banks (banks),
        .irq   (stamp_irq)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_flat
        assign bank_flat[g*REC_W +: REC_W] = banks[g];
    end
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk
    import evt_stamp_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       func_en,
    input logic                       ovw_en,
    input logic                       clr_stb,
    input logic [NUM_BANKS*REC_W-1:0] bank_flat,
    input logic                       stamp_irq
);
    localparam int LAST = (NUM_BANKS - 1) * REC_W;

    logic [REC_W-1:0]  b0, b1;
    logic [CODE_W-1:0] b0_code, last_code;

    assign b0        = bank_flat[0 +: REC_W];
    assign b1        = bank_flat[REC_W +: REC_W];
    assign b0_code   = b0[REC_W-FIELD_W +: CODE_W];
    assign last_code = bank_flat[LAST + REC_W - FIELD_W +: CODE_W];

    // R2
    shift_on_store_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_irq |-> b1 == $past(b0));

    // R4
    idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !func_en |=> !stamp_irq);

    // R7
    frozen_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        (!ovw_en && last_code != 3'd0 && !clr_stb) |=> $stable(bank_flat));

    // R9
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr_stb |=> (bank_flat == '0 && !stamp_irq));

    // R10
    irq_has_code_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_irq |-> (b0_code >= 3'd1 && b0_code <= 3'd4));
endmodule

bind evt_stamp_bank evt_stamp_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .func_en   (func_en),
    .ovw_en    (ovw_en),
    .clr_stb   (clr_stb),
    .bank_flat (bank_flat),
    .stamp_irq (stamp_irq)
);

// File: tb/evt_stamp_bank_tb.sv
`timescale 1ns/1ps
module evt_stamp_bank_tb_top;
    logic clk = 1'b0;
    logic rst, func_en, ovw_en, clr_stb, en_lowbat, en_supply, en_din;
    logic din_pol, din_lvl, to_main_p, to_bak_p, lowbat_p;
    logic [7:0] t_subsec, t_sec, t_min, t_hour, t_date, t_month, t_year;
    logic [255:0] bank_flat;
    logic stamp_irq;

    int n_chk = 0;
    int n_err = 0;
    logic [63:0] mdl [4];
    int mcnt = 0;

    always #10 clk = ~clk;

    evt_stamp_bank dut_i (
        .clk(clk), .rst(rst), .func_en(func_en), .ovw_en(ovw_en), .clr_stb(clr_stb),
        .en_lowbat(en_lowbat), .en_supply(en_supply), .en_din(en_din),
        .din_pol(din_pol), .din_lvl(din_lvl), .to_main_p(to_main_p),
        .to_bak_p(to_bak_p), .lowbat_p(lowbat_p), .t_subsec(t_subsec),
        .t_sec(t_sec), .t_min(t_min), .t_hour(t_hour), .t_date(t_date),
        .t_month(t_month), .t_year(t_year), .bank_flat(bank_flat),
        .stamp_irq(stamp_irq)
    );

    task automatic set_time(input logic [7:0] b);
        t_subsec = b; t_sec = b + 8'd1; t_min = b + 8'd2; t_hour = b + 8'd3;
        t_date = b + 8'd4; t_month = b + 8'd5; t_year = b + 8'd6;
    endtask

    function automatic logic [63:0] cur_rec(input logic [2:0] code);
        return {5'b0, code, t_year, t_month, t_date, t_hour, t_min, t_sec, t_subsec};
    endfunction

    task automatic check_all(input string tag, input logic exp_irq);
        for (int g = 0; g < 4; g++) begin
            n_chk++;
            if (bank_flat[g*64 +: 64] !== mdl[g]) begin
                n_err++;
                $display("FAIL %s bank%0d: actual=%h expected=%h", tag, g,
                         bank_flat[g*64 +: 64], mdl[g]);
            end
        end
        n_chk++;
        if (stamp_irq !== exp_irq) begin
            n_err++;
            $display("FAIL %s/R10 irq: actual=%b expected=%b", tag, stamp_irq, exp_irq);
        end
    endtask

    // Drives one cycle of stimulus; code is the expected cause (0 = ignored).
    task automatic ev(input logic lb, input logic tm, input logic tb, input logic dn,
                      input logic [2:0] code, input string tag);
        logic take;
        @(negedge clk);
        lowbat_p = lb; to_main_p = tm; to_bak_p = tb; din_lvl = dn;
        take = (code != 3'd0) && !clr_stb && (ovw_en || mcnt < 4);
        if (take) begin
            for (int g = 3; g > 0; g--) mdl[g] = mdl[g-1];
            mdl[0] = cur_rec(code);
            if (mcnt < 4) mcnt++;
        end
        if (clr_stb) begin
            for (int g = 0; g < 4; g++) mdl[g] = '0;
            mcnt = 0;
        end
        @(negedge clk);
        lowbat_p = 0; to_main_p = 0; to_bak_p = 0; clr_stb = 0;
        check_all(tag, take);
        set_time(t_subsec + 8'h11);
    endtask

    task automatic do_clear(input string tag);
        clr_stb = 1'b1;
        ev(0, 0, 0, din_lvl, 3'd0, tag);
    endtask

    task automatic t_reset;
        for (int g = 0; g < 4; g++) mdl[g] = '0;
        check_all("R1 reset", 1'b0);
    endtask

    task automatic t_codes;
        ev(0, 0, 0, 1'b0, 3'd1, "R3 din fall code1");
        ev(0, 1, 0, 1'b0, 3'd2, "R3 to_main code2");
        ev(0, 0, 1, 1'b0, 3'd3, "R2 to_bak shift");
        ev(1, 0, 0, 1'b0, 3'd4, "R3 lowbat code4");
    endtask

    task automatic t_freeze;
        ev(1, 0, 0, 1'b0, 3'd4, "R7 full ignores lowbat");
        ev(0, 0, 0, 1'b1, 3'd0, "R7 full rise ignored");
        ev(0, 0, 0, 1'b0, 3'd1, "R7 full ignores din");
    endtask

    task automatic t_clear;
        clr_stb = 1'b1;
        ev(1, 0, 0, 1'b0, 3'd4, "R9 clear beats event");
        ev(0, 1, 0, 1'b0, 3'd2, "R9 resume at bank0");
    endtask

    task automatic t_enables;
        en_supply = 0;
        ev(0, 1, 0, 1'b0, 3'd0, "R4 supply disabled");
        ev(0, 0, 1, 1'b0, 3'd0, "R4 supply disabled bak");
        en_supply = 1; en_lowbat = 0;
        ev(1, 0, 0, 1'b0, 3'd0, "R4 lowbat disabled");
        en_lowbat = 1; en_din = 0;
        ev(0, 0, 0, 1'b1, 3'd0, "R4 din disabled rise");
        ev(0, 0, 0, 1'b0, 3'd0, "R4 din disabled fall");
        en_din = 1; func_en = 0;
        ev(1, 1, 0, 1'b0, 3'd0, "R4 func off");
        func_en = 1;
    endtask

    task automatic t_pol;
        @(negedge clk); din_pol = 1'b1;
        ev(0, 0, 0, 1'b1, 3'd1, "R5 rise with pol1");
        ev(0, 0, 0, 1'b0, 3'd0, "R5 fall ignored pol1");
        @(negedge clk); din_pol = 1'b0;
        ev(0, 0, 0, 1'b1, 3'd0, "R5 rise ignored pol0");
    endtask

    task automatic t_prio;
        do_clear("R9 clear before prio");
        ev(1, 1, 1, 1'b0, 3'd4, "R6 lowbat wins");
        ev(0, 1, 1, 1'b1, 3'd2, "R6 to_main wins");
        ev(0, 0, 1, 1'b0, 3'd3, "R6 to_bak over din");
    endtask

    task automatic t_ovw;
        ovw_en = 1'b1;
        ev(0, 1, 0, 1'b0, 3'd2, "R8 fill fourth");
        ev(1, 0, 0, 1'b0, 3'd4, "R8 drop oldest");
        ev(0, 0, 1, 1'b0, 3'd3, "R8 drop again");
        ev(0, 0, 0, 1'b1, 3'd0, "R8 rise ignored pol0");
        ev(0, 0, 0, 1'b0, 3'd1, "R8 din drops oldest");
        ovw_en = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        rst = 1; func_en = 1; ovw_en = 0; clr_stb = 0; en_lowbat = 1;
        en_supply = 1; en_din = 1; din_pol = 0; din_lvl = 1;
        to_main_p = 0; to_bak_p = 0; lowbat_p = 0;
        set_time(8'h10);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_codes();
        t_freeze();
        t_clear();
        t_enables();
        t_pol();
        t_prio();
        t_ovw();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule